// File: doc/BRIEF.md
# Interrupt Vector Entry Fetcher

This block turns an interrupt type number into the handler address that a real-mode processor would jump to. When it accepts a start request it reads the four-byte table entry for that type from memory. The memory port is one byte wide and synchronous, and the block issues one read at a time. From those four bytes it builds a 16-bit instruction-pointer word and a 16-bit code-segment word. It presents both words together with a single-cycle completion strobe.

The table starts at address 0 and covers the first 1024 bytes. Each of the 256 type numbers owns four consecutive bytes, so an entry begins at the type number times four. The offset word comes first and the segment word follows it. Each word is stored low byte first. The surrounding core raises the start request and waits for the strobe. The memory (or a bus bridge in front of it) answers each read strobe with a data-valid pulse some number of cycles later.

Top module: `vf_vector_fetch`

## Requirements
- R1: For type number n the block reads the byte addresses 4n, 4n+1, 4n+2 and 4n+3, strictly in that ascending order, once each.
- R2: The read strobe is a single-cycle pulse. No new read strobe is raised while an earlier read still lacks its data-valid, and the address stays unchanged until that data-valid arrives.
- R3: The instruction-pointer output equals the byte at 4n+1 in bits 15:8 and the byte at 4n in bits 7:0.
- R4: The code-segment output equals the byte at 4n+3 in bits 15:8 and the byte at 4n+2 in bits 7:0.
- R5: Done is high for exactly one cycle, namely the cycle after the cycle in which the fourth data-valid is sampled. The new outputs appear in that same cycle.
- R6: The instruction-pointer and code-segment outputs change only in a cycle where done is high. Between completions, including during a later fetch, they hold their value.
- R7: A start request raised while a fetch is under way is ignored. The running fetch completes with its own type number, and no further reads or done follow.
- R8: A synchronous reset, whether raised while idle or in the middle of a fetch, returns the block to idle. In the cycle after reset, done and the read strobe are low and both words are zero.
- R9: A data-valid pulse while no read is outstanding is ignored. It produces no done, and neither output word changes.
- R10: Both extreme type numbers are served correctly: type 0 reads bytes 0 to 3, and type 255 reads bytes 1020 to 1023, the last bytes of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to fetch the entry for type_i; taken only while idle |
| type_i | input | TYPE_W (8) | Interrupt type number, sampled with an accepted start |
| mem_addr_o | output | ADDR_W (20) | Byte address of the current read |
| mem_rd_o | output | 1 | One-cycle read strobe |
| mem_data_i | input | BYTE_W (8) | Read data, taken when mem_valid_i is high |
| mem_valid_i | input | 1 | Data-valid for the outstanding read |
| ip_o | output | 16 | Handler offset word of the last completed fetch |
| cs_o | output | 16 | Handler segment word of the last completed fetch |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A table of eight type numbers is fetched. It includes 0, 1, 100, 254 and 255, and each entry is paired with a read latency between one and four cycles. The memory holds a computed pattern in which every byte of an entry differs from its neighbours. Because of this, a swapped byte, a swapped word, a wrong stride or a misread lane each gives a different value, and a latency-dependent timing fault moves the done strobe away from its expected cycle. Directed runs then add three cases: a second start in the middle of a fetch, stray data-valid pulses while idle, and a reset in the middle of a fetch. These show whether the block's state is kept or correctly discarded in each case.

// File: rtl/vf_pkg.sv
package vf_pkg;

   typedef enum logic [1:0] {
      VF_IDLE  = 2'd0,
      VF_ISSUE = 2'd1,
      VF_AWAIT = 2'd2
   } vf_state_e;

endpackage

// File: rtl/vf_sequencer.sv
module vf_sequencer #(
   parameter int LANES = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             valid_i,
   output logic             accept_o,
   output logic             issue_o,
   output logic             capture_o,
   output logic             last_o,
   output logic [IDX_W-1:0] lane_o
);
   import vf_pkg::*;

   localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

   vf_state_e        state_q;
   logic [IDX_W-1:0] lane_q;

   always_comb begin
      accept_o  = (state_q == VF_IDLE) && start_i;
      issue_o   = (state_q == VF_ISSUE);
      capture_o = (state_q == VF_AWAIT) && valid_i;
      last_o    = (lane_q == LAST_LANE);
      lane_o    = lane_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= VF_IDLE;
         lane_q  <= '0;
      end else begin
         unique case (state_q)
            VF_IDLE: begin
               if (start_i) begin
                  state_q <= VF_ISSUE;
                  lane_q  <= '0;
               end
            end
            VF_ISSUE: begin
               state_q <= VF_AWAIT;
            end
            VF_AWAIT: begin
               if (valid_i) begin
                  if (lane_q == LAST_LANE) begin
                     state_q <= VF_IDLE;
                     lane_q  <= '0;
                  end else begin
                     state_q <= VF_ISSUE;
                     lane_q  <= lane_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q <= VF_IDLE;
               lane_q  <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/vf_addr_gen.sv
module vf_addr_gen #(
   parameter int TYPE_W     = 8,
   parameter int ADDR_W     = 20,
   parameter int IDX_W      = 2,
   parameter int TABLE_BASE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [TYPE_W-1:0] type_i,
   input  logic [IDX_W-1:0]  lane_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [TYPE_W-1:0] type_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         type_q <= '0;
      end else if (load_i) begin
         type_q <= type_i;
      end
   end

   generate
      if (TABLE_BASE == 0) begin : g_zero_base
         // Table at address 0: entry address is pure wiring, no adder.
         always_comb addr_o = ADDR_W'({type_q, lane_i});
      end else begin : g_offset_base
         localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
         always_comb addr_o = BASE_A + (ADDR_W'(type_q) << IDX_W) + ADDR_W'(lane_i);
      end
   endgenerate

endmodule

// File: rtl/vf_entry_asm.sv
module vf_entry_asm #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2,
   parameter int IDX_W      = 2,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         capture_i,
   input  logic                         last_i,
   input  logic [IDX_W-1:0]             lane_i,
   input  logic [BYTE_W-1:0]            data_i,
   output logic [BYTE_W*WORD_BYTES-1:0] ip_o,
   output logic [BYTE_W*WORD_BYTES-1:0] cs_o,
   output logic                         done_o
);

   localparam int ENTRY_BYTES = 2 * WORD_BYTES;
   localparam int WORD_W      = BYTE_W * WORD_BYTES;

   logic [ENTRY_BYTES-1:0][BYTE_W-1:0] lane_q;
   logic [ENTRY_BYTES-1:0][BYTE_W-1:0] lane_d;
   logic [1:0][WORD_W-1:0]             word_d;
   logic [WORD_W-1:0]                  ip_q;
   logic [WORD_W-1:0]                  cs_q;
   logic                               done_q;

   // Merge the incoming byte into its lane so the final byte can be used
   // in the same cycle it arrives.
   generate
      for (genvar g = 0; g < ENTRY_BYTES; g++) begin : g_lane
         assign lane_d[g] = (capture_i && (lane_i == IDX_W'(g))) ? data_i : lane_q[g];
      end

      for (genvar w = 0; w < 2; w++) begin : g_word
         for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            if (LITTLE_END) begin : g_le
               assign word_d[w][b*BYTE_W +: BYTE_W] = lane_d[w*WORD_BYTES + b];
            end else begin : g_be
               assign word_d[w][b*BYTE_W +: BYTE_W] = lane_d[w*WORD_BYTES + WORD_BYTES-1-b];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         lane_q <= '0;
         ip_q   <= '0;
         cs_q   <= '0;
         done_q <= 1'b0;
      end else begin
         lane_q <= lane_d;
         done_q <= capture_i && last_i;
         if (capture_i && last_i) begin
            ip_q <= word_d[0];
            cs_q <= word_d[1];
         end
      end
   end

   assign ip_o   = ip_q;
   assign cs_o   = cs_q;
   assign done_o = done_q;

endmodule

// File: rtl/vf_vector_fetch.sv
module vf_vector_fetch #(
   parameter int TYPE_W     = 8,
   parameter int ADDR_W     = 20,
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2,
   parameter int TABLE_BASE = 0,
   parameter bit LITTLE_END = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         start_i,
   input  logic [TYPE_W-1:0]            type_i,
   output logic [ADDR_W-1:0]            mem_addr_o,
   output logic                         mem_rd_o,
   input  logic [BYTE_W-1:0]            mem_data_i,
   input  logic                         mem_valid_i,
   output logic [BYTE_W*WORD_BYTES-1:0] ip_o,
   output logic [BYTE_W*WORD_BYTES-1:0] cs_o,
   output logic                         done_o
);

   localparam int ENTRY_BYTES = 2 * WORD_BYTES;
   localparam int IDX_W       = $clog2(ENTRY_BYTES);
   localparam int WORD_W      = BYTE_W * WORD_BYTES;

   generate
      if (WORD_BYTES < 1) begin : g_bad_word
         $error("vf_vector_fetch: WORD_BYTES must be at least 1");
      end
      if (ENTRY_BYTES != (1 << IDX_W)) begin : g_bad_stride
         $error("vf_vector_fetch: entry size must be a power of two");
      end
      if (ADDR_W < TYPE_W + IDX_W) begin : g_bad_addr
         $error("vf_vector_fetch: ADDR_W too narrow for the table");
      end
      if ((TABLE_BASE < 0) || ((TABLE_BASE % ENTRY_BYTES) != 0)) begin : g_bad_base
         $error("vf_vector_fetch: TABLE_BASE must be non-negative and entry aligned");
      end
   endgenerate

   logic             accept;
   logic             issue;
   logic             capture;
   logic             last;
   logic [IDX_W-1:0] lane;

   vf_sequencer #(
      .LANES (ENTRY_BYTES),
      .IDX_W (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start_i),
      .valid_i   (mem_valid_i),
      .accept_o  (accept),
      .issue_o   (issue),
      .capture_o (capture),
      .last_o    (last),
      .lane_o    (lane)
   );

   vf_addr_gen #(
      .TYPE_W     (TYPE_W),
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .TABLE_BASE (TABLE_BASE)
   ) u_addr (
      .clk    (clk),
      .rst    (rst),
      .load_i (accept),
      .type_i (type_i),
      .lane_i (lane),
      .addr_o (mem_addr_o)
   );

   vf_entry_asm #(
      .BYTE_W     (BYTE_W),
      .WORD_BYTES (WORD_BYTES),
      .IDX_W      (IDX_W),
      .LITTLE_END (LITTLE_END)
   ) u_asm (
      .clk       (clk),
      .rst       (rst),
      .capture_i (capture),
      .last_i    (last),
      .lane_i    (lane),
      .data_i    (mem_data_i),
      .ip_o      (ip_o),
      .cs_o      (cs_o),
      .done_o    (done_o)
   );

   assign mem_rd_o = issue;

endmodule

// File: rtl/vf_fetch_checker.sv
module vf_fetch_checker #(
   parameter int TYPE_W      = 8,
   parameter int ADDR_W      = 20,
   parameter int IDX_W       = 2,
   parameter int ENTRY_BYTES = 4,
   parameter int WORD_W      = 16,
   parameter int TABLE_BASE  = 0
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic              mem_valid_i,
   input logic [WORD_W-1:0] ip_o,
   input logic [WORD_W-1:0] cs_o,
   input logic              done_o
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TABLE_BASE);
   localparam logic [ADDR_W:0]   SPAN_A = (ADDR_W+1)'(ENTRY_BYTES * (1 << TYPE_W));

   logic [IDX_W:0]    rd_cnt;
   logic              pend;
   logic [ADDR_W-1:0] rel;

   assign rel = mem_addr_o - BASE_A;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_cnt <= '0;
         pend   <= 1'b0;
      end else begin
         if (done_o)        rd_cnt <= '0;
         else if (mem_rd_o) rd_cnt <= rd_cnt + 1'b1;
         if (mem_rd_o)         pend <= 1'b1;
         else if (mem_valid_i) pend <= 1'b0;
      end
   end

   // R1: reads walk the lanes of one entry in ascending order
   a_r1_lane_order: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |-> (rel[IDX_W-1:0] == rd_cnt[IDX_W-1:0]));

   // R10: every read stays inside the vector table
   a_r10_in_table: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |-> ({1'b0, rel} < SPAN_A));

   // R2: one outstanding read, single-cycle strobe, address held
   a_r2_single_outstanding: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |-> !pend);
   a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
      mem_rd_o |=> !mem_rd_o);
   a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
      pend |-> $stable(mem_addr_o));

   // R5: done is a pulse and only follows a full entry of reads
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);
   a_r5_done_after_entry: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (rd_cnt == (IDX_W+1)'(ENTRY_BYTES)));

   // R6: outputs move only together with done
   a_r6_hold_words: assert property (@(posedge clk) disable iff (rst)
      !done_o |-> ($stable(ip_o) && $stable(cs_o)));

   // R8: reset leaves the block idle with cleared words
   a_r8_reset_idle: assert property (@(posedge clk)
      rst |=> (!done_o && !mem_rd_o && (ip_o == '0) && (cs_o == '0)));

endmodule

bind vf_vector_fetch vf_fetch_checker #(
   .TYPE_W      (TYPE_W),
   .ADDR_W      (ADDR_W),
   .IDX_W       (IDX_W),
   .ENTRY_BYTES (ENTRY_BYTES),
   .WORD_W      (WORD_W),
   .TABLE_BASE  (TABLE_BASE)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .mem_addr_o  (mem_addr_o),
   .mem_rd_o    (mem_rd_o),
   .mem_valid_i (mem_valid_i),
   .ip_o        (ip_o),
   .cs_o        (cs_o),
   .done_o      (done_o)
);

// File: tb/sim_vf_vector_fetch.sv
module sim_vf_vector_fetch;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_i = 1'b0;
   logic [7:0]  type_i = '0;
   logic [19:0] mem_addr_o;
   logic        mem_rd_o;
   logic [7:0]  mem_data_i = '0;
   logic        mem_valid_i = 1'b0;
   logic [15:0] ip_o;
   logic [15:0] cs_o;
   logic        done_o;

   vf_vector_fetch u0 (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start_i),
      .type_i      (type_i),
      .mem_addr_o  (mem_addr_o),
      .mem_rd_o    (mem_rd_o),
      .mem_data_i  (mem_data_i),
      .mem_valid_i (mem_valid_i),
      .ip_o        (ip_o),
      .cs_o        (cs_o),
      .done_o      (done_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit reported = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] mem_byte(input int a);
      return 8'((a * 29) ^ (a >> 2) ^ 8'h5C);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // memory model
   int  lat = 1;
   bit  inject = 0;
   int  log_addr [0:15];
   int  log_n = 0;
   int  vcount = 0;
   int  last_vcyc = 0;
   int  r2_bad = 0;
   bit  pend = 0;
   int  cnt = 0;
   logic [19:0] paddr = '0;

   always @(negedge clk) begin
      mem_valid_i = 1'b0;
      if (rst) begin
         pend = 0;
         cnt  = 0;
      end else if (inject) begin
         mem_valid_i = 1'b1;
         mem_data_i  = 8'hA5;
      end else if (mem_rd_o) begin
         if (pend) r2_bad++;
         if (log_n < 16) log_addr[log_n] = int'(mem_addr_o);
         log_n++;
         pend  = 1;
         paddr = mem_addr_o;
         cnt   = lat;
      end else if (pend) begin
         if (mem_addr_o != paddr) r2_bad++;
         cnt--;
         if (cnt <= 0) begin
            mem_valid_i = 1'b1;
            mem_data_i  = mem_byte(int'(paddr));
            pend        = 0;
            vcount++;
            last_vcyc   = cyc;
         end
      end
   end

   task automatic do_fetch(input logic [7:0] v, input int l, input bit intrude, input logic [7:0] iv);
      logic [15:0] ip0, cs0, eip, ecs;
      bit hold_ok, addr_ok;
      int n, dcyc, bad_a;
      lat = l; log_n = 0; vcount = 0; r2_bad = 0;
      ip0 = ip_o; cs0 = cs_o; hold_ok = 1;
      start_i = 1'b1; type_i = v;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < 400) begin
         if (ip_o != ip0 || cs_o != cs0) hold_ok = 0;
         if (intrude && n == 2) begin start_i = 1'b1; type_i = iv; end
         else start_i = 1'b0;
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      dcyc = cyc;
      eip = {mem_byte(4*v+1), mem_byte(4*v)};
      ecs = {mem_byte(4*v+3), mem_byte(4*v+2)};
      chk(done_o, "R5 done reached", 32'(done_o), 1);
      chk(dcyc == last_vcyc + 1, "R5 done one cycle after fourth valid", dcyc, last_vcyc + 1);
      chk(ip_o == eip, "R3 offset word", ip_o, eip);
      chk(cs_o == ecs, "R4 segment word", cs_o, ecs);
      addr_ok = (log_n == 4);
      bad_a = 0;
      for (int k = 0; k < 4; k++) begin
         if (addr_ok && log_addr[k] != 4*v + k) begin addr_ok = 0; bad_a = log_addr[k]; end
      end
      chk(addr_ok, "R1 read address sequence", (log_n == 4) ? bad_a : log_n, 4*v);
      chk(hold_ok, "R6 words held until completion", ip_o, ip0);
      chk(r2_bad == 0, "R2 one outstanding read, address held", r2_bad, 0);
      @(negedge clk);
      chk(!done_o, "R5 done lasts one cycle", 32'(done_o), 0);
   endtask

   localparam int NV = 8;
   localparam logic [7:0] TV [NV] = '{8'd0, 8'd1, 8'd100, 8'd255, 8'd37, 8'd128, 8'd254, 8'd7};
   localparam int         TL [NV] = '{1, 2, 3, 1, 4, 2, 1, 3};

   initial begin
      logic [15:0] ipk, csk;
      bit seen;
      repeat (3) @(negedge clk);
      chk(!done_o, "R8 reset done low", 32'(done_o), 0);
      chk(!mem_rd_o, "R8 reset no read", 32'(mem_rd_o), 0);
      chk(ip_o == 0, "R8 reset offset zero", ip_o, 0);
      chk(cs_o == 0, "R8 reset segment zero", cs_o, 0);
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         do_fetch(TV[i], TL[i], 0, 8'd0);
         if (TV[i] == 8'd0)
            chk(log_addr[0] == 0 && log_addr[3] == 3, "R10 type 0 at bytes 0..3", log_addr[0], 0);
         if (TV[i] == 8'd255)
            chk(log_addr[0] == 1020 && log_addr[3] == 1023, "R10 type 255 ends at byte 1023", log_addr[3], 1023);
      end

      // R7: second start during a fetch
      do_fetch(8'd5, 2, 1, 8'd200);
      seen = 0;
      repeat (6) begin @(negedge clk); if (done_o) seen = 1; end
      chk(log_n == 4 && !seen, "R7 no further fetch after ignored start", log_n, 4);

      // R9: stray data-valid while idle
      ipk = ip_o; csk = cs_o; seen = 0;
      inject = 1;
      @(negedge clk); if (done_o) seen = 1;
      @(negedge clk); if (done_o) seen = 1;
      inject = 0;
      repeat (4) begin @(negedge clk); if (done_o) seen = 1; end
      chk(!seen, "R9 stray valid gives no done", 32'(seen), 0);
      chk(ip_o == ipk && cs_o == csk, "R9 stray valid leaves words", {ip_o, cs_o}, {ipk, csk});
      do_fetch(8'd42, 1, 0, 8'd0);

      // R8: reset in the middle of a fetch
      lat = 3;
      start_i = 1'b1; type_i = 8'd9;
      @(negedge clk); start_i = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(!done_o && !mem_rd_o, "R8 mid-fetch reset idle", {done_o, mem_rd_o}, 0);
      chk(ip_o == 0 && cs_o == 0, "R8 mid-fetch reset clears words", {ip_o, cs_o}, 0);
      rst = 1'b0;
      log_n = 0; seen = 0;
      repeat (8) begin @(negedge clk); if (done_o) seen = 1; end
      chk(!seen && log_n == 0, "R8 fetch abandoned after reset", log_n, 0);
      do_fetch(8'd9, 2, 0, 8'd0);

      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

endmodule